// File: doc/BRIEF.md
# Five-State Coherent Line Controller

This block keeps the coherence state and tag of every line in a small direct-mapped cache. Each line is in one of five states: invalid, shared, exclusive, owned or modified. Local accesses, snoop probes from other bus masters and whole-cache commands update that state. Each cycle the block decides whether a local access hits. On a miss it asks for a fill. It asks for a writeback when dirty data would otherwise be lost. It also tells the probe side when this cache must supply the line's data. The data arrays and the bus timing sit outside the block. The block only produces the request strobes and addresses, and they are valid in the same cycle as the inputs.

A local access carries an address that is split into a tag (upper bits) and an index (lower `IDX_W` bits). It also carries a write flag and a cache-disabled flag. A fill takes its sharing answer from `fill_shared` in the miss cycle. A probe carries an address, a write flag and a flag saying whether the requester will keep a copy. Two commands act on the whole cache: a one-cycle clear, and a sweep that writes back dirty lines before clearing them. A write miss takes two cycles. While it completes, and while the sweep runs, `busy` is high.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset, and in the cycle after an accepted `inv_all`, every line is invalid, so any local access misses. `loc_state_new` encodes states as invalid=0, shared=1, exclusive=2, owned=3, modified=4.
- R2: A cacheable local read that hits leaves the line's state unchanged.
- R3: A cacheable local write that hits leaves the line modified, whatever valid state it was in.
- R4: A cacheable local read miss raises `miss_req` and fills the line exclusive when `fill_shared` is 0, or shared when it is 1.
- R5: A cacheable local write miss raises `miss_req` and shows exclusive on `loc_state_new`. `busy` is high for the next cycle, after which the line is modified.
- R6: A write probe that hits a valid line leaves it invalid. `supply_req` is raised when the line was modified or owned.
- R7: A read probe from a caching requester that hits moves modified to owned and exclusive to shared, and leaves owned and shared as they are. `supply_req` is raised for modified or owned.
- R8: A read probe from a non-caching requester never changes the state. It still raises `supply_req` for a modified or owned line.
- R9: A cache-disabled access that hits invalidates the line. It raises `wb_req` with `wb_addr` equal to the access address if the line was modified or owned. A cache-disabled miss requests no fill.
- R10: A cacheable miss that replaces a valid modified or owned line raises `wb_req`, with `wb_addr` = {old tag, index}. A clean victim raises no writeback.
- R11: An accepted `wbinv_all` holds `busy` high for 2^IDX_W cycles from the next cycle. It visits one line per cycle in ascending index, raises `wb_req` with {tag, index} for each modified or owned line, and leaves every line invalid.
- R12: When a probe and a local access hit the same index in one cycle, the probe is applied first, and the local access sees the state the probe left.
- R13: While `busy` is high, local accesses, `inv_all` and `wbinv_all` are ignored. Probes are still serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_vld | input | 1 | Local access present |
| loc_wr | input | 1 | Local access is a write |
| loc_nocache | input | 1 | Local access is cache-disabled |
| loc_addr | input | TAG_W+IDX_W | Local address {tag, index} |
| fill_shared | input | 1 | Another cache holds the line being filled |
| prb_vld | input | 1 | Probe present |
| prb_wr | input | 1 | Probe is for modification |
| prb_keeps | input | 1 | Read probe requester will cache the line |
| prb_addr | input | TAG_W+IDX_W | Probe address {tag, index} |
| inv_all | input | 1 | Invalidate every line |
| wbinv_all | input | 1 | Write back dirty lines, then invalidate all |
| busy | output | 1 | Write-miss completion or sweep in progress |
| loc_hit | output | 1 | Accepted local access hits |
| loc_state_new | output | 3 | State the local line takes at the next edge |
| miss_req | output | 1 | Fill request for a cacheable miss |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | TAG_W+IDX_W | Writeback line address |
| prb_hit | output | 1 | Probe hits a valid line |
| supply_req | output | 1 | This cache supplies the probed data |

## Verification
A snoop probe and a local access can arrive at the same index in the same cycle. The bench provokes this twice. First, a write probe meets a local read on a modified line. The expected result is that data is supplied, the local read misses, a fresh exclusive fill is requested and no victim writeback is raised, because the probe already took the dirty copy. Second, a caching read probe meets a local read on an exclusive line. The local access must then report shared. Probes that arrive while a write miss completes are also applied after the pending write has made the line modified.

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     loc_vld,
  input  logic                     loc_wr,
  input  logic                     loc_nocache,
  input  logic [TAG_W+IDX_W-1:0]   loc_addr,
  input  logic                     fill_shared,
  input  logic                     prb_vld,
  input  logic                     prb_wr,
  input  logic                     prb_keeps,
  input  logic [TAG_W+IDX_W-1:0]   prb_addr,
  input  logic                     inv_all,
  input  logic                     wbinv_all,
  output logic                     busy,
  output logic                     loc_hit,
  output logic [2:0]               loc_state_new,
  output logic                     miss_req,
  output logic                     wb_req,
  output logic [TAG_W+IDX_W-1:0]   wb_addr,
  output logic                     prb_hit,
  output logic                     supply_req
);
  timeunit 1ns; timeprecision 1ps;

  localparam int LINES = 1 << IDX_W;

  typedef enum logic [2:0] {ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4} st_t;

  st_t              st_q   [LINES];
  st_t              st_nx  [LINES];
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [LINES-1:0] valid_vec;

  logic             pend_q, walk_q;
  logic [IDX_W-1:0] pend_idx_q, walk_idx_q;

  logic [IDX_W-1:0] idx_l, idx_p;
  logic [TAG_W-1:0] tag_l, tag_p;
  st_t              s0_p, s0_l, s1_l, s1_w, prb_nx, loc_nx;
  logic             loc_go, inv_go, wbinv_go, loc_fill, loc_wb, walk_wb, dirty_l;

  assign idx_l = loc_addr[IDX_W-1:0];
  assign tag_l = loc_addr[TAG_W+IDX_W-1:IDX_W];
  assign idx_p = prb_addr[IDX_W-1:0];
  assign tag_p = prb_addr[TAG_W+IDX_W-1:IDX_W];

  assign busy     = pend_q || walk_q;
  assign inv_go   = inv_all && !busy;
  assign wbinv_go = wbinv_all && !busy && !inv_all;
  assign loc_go   = loc_vld && !busy && !inv_all && !wbinv_all;

  // probe view: a pending write-miss completion lands before the probe
  assign s0_p    = (pend_q && pend_idx_q == idx_p) ? ST_M : st_q[idx_p];
  assign prb_hit = prb_vld && (s0_p != ST_I) && (tag_q[idx_p] == tag_p);
  assign supply_req = prb_hit && (s0_p == ST_M || s0_p == ST_O);

  always_comb begin
    prb_nx = s0_p;
    if (prb_wr)
      prb_nx = ST_I;
    else if (prb_keeps) begin
      case (s0_p)
        ST_M:    prb_nx = ST_O;
        ST_E:    prb_nx = ST_S;
        default: prb_nx = s0_p;
      endcase
    end
  end

  // local view: sees the state left by a same-index probe
  assign s0_l    = (pend_q && pend_idx_q == idx_l) ? ST_M : st_q[idx_l];
  assign s1_l    = (prb_hit && idx_p == idx_l) ? prb_nx : s0_l;
  assign dirty_l = (s1_l == ST_M) || (s1_l == ST_O);
  assign loc_hit = loc_go && (s1_l != ST_I) && (tag_q[idx_l] == tag_l);

  always_comb begin
    loc_fill = 1'b0;
    loc_nx   = s1_l;
    if (loc_nocache) begin
      if (loc_hit) loc_nx = ST_I;
    end else if (loc_hit) begin
      if (loc_wr) loc_nx = ST_M;
    end else begin
      loc_fill = 1'b1;
      loc_nx   = (loc_wr || !fill_shared) ? ST_E : ST_S;
    end
  end

  assign loc_state_new = loc_nx;
  assign miss_req      = loc_go && !loc_nocache && !loc_hit;
  assign loc_wb        = loc_go && dirty_l && (loc_nocache == loc_hit);

  assign s1_w    = (prb_hit && idx_p == walk_idx_q) ? prb_nx : st_q[walk_idx_q];
  assign walk_wb = walk_q && (s1_w == ST_M || s1_w == ST_O);

  assign wb_req  = loc_wb || walk_wb;
  assign wb_addr = walk_q ? {tag_q[walk_idx_q], walk_idx_q} : {tag_q[idx_l], idx_l};

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      st_nx[i] = st_q[i];
      if (pend_q && pend_idx_q == IDX_W'(i))        st_nx[i] = ST_M;
      if (prb_hit && idx_p == IDX_W'(i))            st_nx[i] = prb_nx;
      if (walk_q && walk_idx_q == IDX_W'(i))        st_nx[i] = ST_I;
      if (loc_go && idx_l == IDX_W'(i))             st_nx[i] = loc_nx;
      if (inv_go)                                   st_nx[i] = ST_I;
    end
  end

  always_comb begin
    for (int i = 0; i < LINES; i++) valid_vec[i] = (st_q[i] != ST_I);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      walk_q     <= 1'b0;
      walk_idx_q <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) st_q[i] <= st_nx[i];
      pend_q     <= loc_go && loc_wr && !loc_nocache && !loc_hit;
      pend_idx_q <= idx_l;
      if (wbinv_go) begin
        walk_q     <= 1'b1;
        walk_idx_q <= '0;
      end else if (walk_q) begin
        if (walk_idx_q == IDX_W'(LINES - 1)) walk_q <= 1'b0;
        walk_idx_q <= walk_idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (loc_go && loc_fill) tag_q[idx_l] <= tag_l;
  end

  st_t              chk_st_q;
  logic [IDX_W-1:0] chk_idx_q;
  always_ff @(posedge clk) begin
    chk_st_q  <= s1_l;
    chk_idx_q <= idx_l;
  end

  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_go |=> (valid_vec == '0)); // R1
  AST_RDHIT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_hit && !loc_wr && !loc_nocache) |=> (st_q[chk_idx_q] == chk_st_q)); // R2
  AST_WRHIT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_hit && loc_wr && !loc_nocache) |=> (st_q[chk_idx_q] == ST_M)); // R3
  AST_WMISS_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && loc_wr) |=> (busy && st_q[chk_idx_q] == ST_E)); // R5
  AST_WB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (walk_q || loc_go)); // R9
  AST_WALK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_q && walk_idx_q == IDX_W'(LINES - 1)) |=> !walk_q); // R11
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!miss_req && !loc_hit)); // R13
endmodule

// File: tb/sim_moesi_line_ctrl.sv
module sim_moesi_line_ctrl;
  timeunit 1ns; timeprecision 1ps;

  localparam int IW = 2;
  localparam int TW = 3;
  localparam int AW = IW + TW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loc_vld, loc_wr, loc_nocache, fill_shared;
  logic prb_vld, prb_wr, prb_keeps, inv_all, wbinv_all;
  logic [AW-1:0] loc_addr, prb_addr;
  logic busy, loc_hit, miss_req, wb_req, prb_hit, supply_req;
  logic [2:0] loc_state_new;
  logic [AW-1:0] wb_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  moesi_line_ctrl #(.IDX_W(IW), .TAG_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .loc_vld(loc_vld), .loc_wr(loc_wr),
    .loc_nocache(loc_nocache), .loc_addr(loc_addr), .fill_shared(fill_shared),
    .prb_vld(prb_vld), .prb_wr(prb_wr), .prb_keeps(prb_keeps), .prb_addr(prb_addr),
    .inv_all(inv_all), .wbinv_all(wbinv_all), .busy(busy), .loc_hit(loc_hit),
    .loc_state_new(loc_state_new), .miss_req(miss_req), .wb_req(wb_req),
    .wb_addr(wb_addr), .prb_hit(prb_hit), .supply_req(supply_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    loc_vld = 0; loc_wr = 0; loc_nocache = 0; fill_shared = 0;
    prb_vld = 0; prb_wr = 0; prb_keeps = 0; inv_all = 0; wbinv_all = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  function automatic logic [AW-1:0] ad(input int tag, input int idx);
    return AW'(tag * (1 << IW) + idx);
  endfunction

  task automatic loc(input bit wr, input bit nc, input logic [AW-1:0] a);
    loc_vld = 1; loc_wr = wr; loc_nocache = nc; loc_addr = a;
  endtask

  task automatic prb(input bit wr, input bit keeps, input logic [AW-1:0] a);
    prb_vld = 1; prb_wr = wr; prb_keeps = keeps; prb_addr = a;
  endtask

  task automatic clear();
    inv_all = 1;
    step();
  endtask

  // states: 0=I 1=S 2=E 3=O 4=M
  task automatic setst(input int idx, input int tag, input int st);
    case (st)
      1: begin loc(0, 0, ad(tag, idx)); fill_shared = 1; step(); end
      2: begin loc(0, 0, ad(tag, idx)); step(); end
      3: begin loc(1, 0, ad(tag, idx)); step(); step(); prb(0, 1, ad(tag, idx)); step(); end
      4: begin loc(1, 0, ad(tag, idx)); step(); step(); end
      default: ;
    endcase
  endtask

  task automatic look(input int idx, input int tag, input int exp, input string req);
    loc(0, 0, ad(tag, idx));
    #1;
    chk(req, loc_hit, exp != 0);
    if (exp != 0) chk(req, loc_state_new, exp);
    step();
  endtask

  function automatic int exp_next(input int st, input int ev);
    case (ev)
      0: return (st == 0) ? 2 : st;
      1: return 4;
      2: return (st == 4) ? 3 : (st == 2) ? 1 : st;
      3: return st;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    loc_addr = '0; prb_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      loc(0, 0, ad(1, i));
      #1;
      chk("R1 reset hit", loc_hit, 0);
      chk("R1 reset busy", busy, 0);
      step();
    end

    // sweep: every line, every state, every event
    for (int idx = 0; idx < 4; idx++)
      for (int st = 0; st < 5; st++)
        for (int ev = 0; ev < 6; ev++) begin
          int tag;
          bit dirty;
          string rq;
          tag = (idx + st + ev) % 8;
          dirty = (st == 3) || (st == 4);
          clear();
          setst(idx, tag, st);
          case (ev)
            0: begin
              rq = (st == 0) ? "R4" : "R2";
              loc(0, 0, ad(tag, idx)); #1;
              chk(rq, miss_req, st == 0);
              step();
            end
            1: begin
              rq = (st == 0) ? "R5" : "R3";
              loc(1, 0, ad(tag, idx)); #1;
              chk(rq, miss_req, st == 0);
              if (st == 0) chk("R5 interim", loc_state_new, 2);
              step();
              if (st == 0) begin
                #1; chk("R5 busy", busy, 1);
                step();
              end
            end
            2: begin
              rq = "R7";
              prb(0, 1, ad(tag, idx)); #1;
              chk(rq, prb_hit, st != 0);
              chk(rq, supply_req, dirty);
              step();
            end
            3: begin
              rq = "R8";
              prb(0, 0, ad(tag, idx)); #1;
              chk(rq, prb_hit, st != 0);
              chk(rq, supply_req, dirty);
              step();
            end
            4: begin
              rq = "R6";
              prb(1, 0, ad(tag, idx)); #1;
              chk(rq, prb_hit, st != 0);
              chk(rq, supply_req, dirty);
              step();
            end
            default: begin
              rq = "R9";
              loc(0, 1, ad(tag, idx)); #1;
              chk(rq, wb_req, dirty);
              chk(rq, miss_req, 0);
              if (dirty) chk("R9 addr", wb_addr, ad(tag, idx));
              step();
            end
          endcase
          look(idx, tag, exp_next(st, ev), rq);
        end

    // R4: shared fill seen directly
    clear();
    loc(0, 0, ad(2, 1)); fill_shared = 1; #1;
    chk("R4 shared fill", loc_state_new, 1);
    step();

    // R10: dirty victim then clean victim
    clear();
    setst(2, 5, 4);
    loc(0, 0, ad(6, 2)); #1;
    chk("R10 miss", miss_req, 1);
    chk("R10 wb", wb_req, 1);
    chk("R10 addr", wb_addr, ad(5, 2));
    chk("R10 fill", loc_state_new, 2);
    step();
    setst(1, 1, 1);
    loc(1, 0, ad(2, 1)); #1;
    chk("R10 clean victim", wb_req, 0);
    step(); step();

    // R12: same-cycle probe and local access
    clear();
    setst(3, 2, 4);
    prb(1, 0, ad(2, 3)); loc(0, 0, ad(2, 3)); #1;
    chk("R12 supply", supply_req, 1);
    chk("R12 loc miss", loc_hit, 0);
    chk("R12 refill", miss_req, 1);
    chk("R12 no victim wb", wb_req, 0);
    chk("R12 state", loc_state_new, 2);
    step();
    look(3, 2, 2, "R12 after");
    clear();
    setst(0, 4, 2);
    prb(0, 1, ad(4, 0)); loc(0, 0, ad(4, 0)); #1;
    chk("R12 probe first", loc_state_new, 1);
    step();

    // R11: writeback-invalidate sweep
    clear();
    setst(0, 1, 4);
    setst(1, 2, 3);
    setst(2, 3, 1);
    setst(3, 4, 2);
    wbinv_all = 1; #1;
    chk("R11 idle before", busy, 0);
    step();
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R11 busy", busy, 1);
      chk("R11 wb", wb_req, k < 2);
      if (k < 2) chk("R11 addr", wb_addr, ad(k + 1, k));
      step();
    end
    #1; chk("R11 done", busy, 0);
    for (int i = 0; i < 4; i++) begin
      look(i, i + 1, 0, "R11 cleared");
      clear();
    end

    // R13: requests ignored while busy, probes serviced
    clear();
    loc(1, 0, ad(1, 0));
    step();
    loc(0, 0, ad(1, 1)); inv_all = 1; prb(0, 0, ad(1, 0)); #1;
    chk("R13 busy", busy, 1);
    chk("R13 no miss", miss_req, 0);
    chk("R13 no hit", loc_hit, 0);
    chk("R13 probe serviced", supply_req, 1);
    step();
    look(0, 1, 4, "R13 inv ignored");
    look(1, 1, 0, "R13 loc ignored");

    // R1: inv_all clears everything
    clear();
    setst(0, 3, 4);
    setst(1, 3, 1);
    clear();
    look(0, 3, 0, "R1 inv");
    clear();
    look(1, 3, 0, "R1 inv");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule